// File: doc/BRIEF.md
# Dual-Strobe Synchronous Burst SRAM

This block is a single-port synchronous RAM organised as two independent 9-bit lanes. Addresses, controls and write data are all registered on the rising clock edge. An access can be opened by either of two active-low address strobes. One comes from a processor and one comes from a cache controller, and the processor strobe has priority. A two-bit burst counter then walks the low address bits through a four-beat sequence, driven by an advance input. A parameter selects an interleaved order (start XOR beat) or a linear order (start plus beat, modulo 4).

A write opened by the processor strobe is deferred by one clock. The write enables seen on the accepting edge are dropped, which gives external tag logic a cycle to approve the write. A write opened by the controller strobe completes on the accepting edge. Read data comes from the location the burst currently points at. Each lane has its own drive-enable output, which stands in for a tristate pad. That enable is gated by an asynchronous, active-low output enable.

Top module: `dsb_burst_sram`

## Requirements
- R1: While reset is asserted, and after it is released until an access is accepted, both bits of `lane_drive` are 0.
- R2: An edge with `sel_n`=0 and at least one strobe low accepts `addr`. With both write enables high this is a read. From the next cycle, each driven lane shows the stored word at that address: lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R3: When both strobes are low on an accepting edge, the processor strobe is the one that takes effect. The write enables on that edge are therefore ignored and nothing is stored.
- R4: With `sel_n`=1 and the controller strobe high, a low processor strobe is ignored. The access in progress keeps its address.
- R5: An edge with `sel_n`=1 and the controller strobe low deselects the block. Both lanes stay undriven until a later edge accepts a new access, even if `sel_n` returns low first.
- R6: A processor-strobe write takes two clocks. The edge after acceptance stores each lane whose enable is sampled low at the burst address.
- R7: A controller-strobe edge with any write enable low stores the enabled lanes of `wdata` at `addr` on that same edge.
- R8: `wr_lo_n` writes lane 0 (`wdata[8:0]`) and `wr_hi_n` writes lane 1 (`wdata[17:9]`). Each lane is written independently of the other.
- R9: With `BURST_LINEAR`=0, the low two address bits at beat k are start XOR k. An edge after acceptance with `adv_n`=0 moves to the next beat and wraps after four beats.
- R10: With `BURST_LINEAR`=1, the low two address bits at beat k are (start + k) mod 4. The upper address bits never change during a burst.
- R11: `adv_n` is ignored on an accepting edge, so the first beat is always the start address.
- R12: A lane is driven only while `oe_n` is 0, with no clock involved. A lane is never driven in a cycle whose opening edge sampled that lane's write enable low, whatever `oe_n` is.
- R13: A lane is driven only in a cycle whose opening edge sampled `sel_n`=0 while an access was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr | input | ADDR_W | Word address, captured on an accepting edge |
| proc_strobe_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_strobe_n | input | 1 | Cache-controller address strobe, active low |
| sel_n | input | 1 | Synchronous chip select, active low |
| wr_lo_n | input | 1 | Lane 0 write enable, active low |
| wr_hi_n | input | 1 | Lane 1 write enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 2*LANE_W | Write data, lane 1 in the upper half |
| rdata | output | 2*LANE_W | Read data at the current burst address |
| lane_drive | output | 2 | Per-lane drive enable, bit 0 for lane 0 |

## Verification
The bench builds the block with `ADDR_W`=6. With only 64 words, the reference model can mirror the whole array, and every location a scenario touches is checked exactly. Two instances share all inputs, one with `BURST_LINEAR`=0 and one with `BURST_LINEAR`=1. A single stimulus stream therefore shows both beat orders, including the wrap after the fourth beat, and the continued-burst writes that land on different words in each instance.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int NUM_LANES = 2;

  // Low address bits for the beat that follows `beat`.
  // Interleaved order flips bit 0 every beat and bit 1 when beat[0] was set.
  function automatic logic [1:0] next_low(input logic [1:0] low,
                                          input logic [1:0] beat,
                                          input bit linear);
    if (linear) next_low = low + 2'd1;
    else        next_low = low ^ {beat[0], 1'b1};
  endfunction
endpackage

// File: rtl/dsb_access_ctrl.sv
module dsb_access_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       proc_strobe_n,
  input  logic       ctrl_strobe_n,
  input  logic [1:0] we_n,
  output logic       start_p,
  output logic       start_c,
  output logic       desel,
  output logic       cont,
  output logic       active_q,
  output logic       sel_q,
  output logic [1:0] wl_q
);
  logic start;

  assign start_p = !sel_n && !proc_strobe_n;
  assign start_c = !sel_n &&  proc_strobe_n && !ctrl_strobe_n;
  assign start   = start_p || start_c;
  assign desel   = sel_n && !ctrl_strobe_n;
  assign cont    = active_q && !start && !desel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= 1'b0;
      wl_q     <= 2'b00;
    end else begin
      if (start)      active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      sel_q <= !sel_n;
      wl_q  <= ~we_n;
    end
  end
endmodule

// File: rtl/dsb_burst_cnt.sv
module dsb_burst_cnt #(
  parameter bit LINEAR = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] load_low,
  input  logic       step,
  output logic [1:0] low_q,
  output logic [1:0] low_nxt
);
  logic [1:0] beat_q;
  logic [1:0] stepped;

  assign stepped = dsb_pkg::next_low(low_q, beat_q, LINEAR);
  assign low_nxt = step ? stepped : low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 2'b00;
      beat_q <= 2'b00;
    end else if (load) begin
      low_q  <= load_low;
      beat_q <= 2'b00;
    end else if (step) begin
      low_q  <= stepped;
      beat_q <= beat_q + 2'd1;
    end
  end
endmodule

// File: rtl/dsb_lane_mem.sv
module dsb_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wd,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
  end

  assign rd = mem[raddr];
endmodule

// File: rtl/dsb_burst_sram.sv
module dsb_burst_sram #(
  parameter int ADDR_W       = 10,
  parameter int LANE_W       = 9,
  parameter bit BURST_LINEAR = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic                                 proc_strobe_n,
  input  logic                                 ctrl_strobe_n,
  input  logic                                 sel_n,
  input  logic                                 wr_lo_n,
  input  logic                                 wr_hi_n,
  input  logic                                 adv_n,
  input  logic                                 oe_n,
  input  logic [dsb_pkg::NUM_LANES*LANE_W-1:0] wdata,
  output logic [dsb_pkg::NUM_LANES*LANE_W-1:0] rdata,
  output logic [dsb_pkg::NUM_LANES-1:0]        lane_drive
);
  localparam int NL   = dsb_pkg::NUM_LANES;
  localparam int HI_W = ADDR_W - 2;

  logic [NL-1:0]     we_n;
  logic              start_p, start_c, desel, cont;
  logic              active_q, sel_q;
  logic [NL-1:0]     wl_q;
  logic [NL-1:0]     wr_lane;
  logic [HI_W-1:0]   base_hi_q;
  logic [1:0]        low_q, low_nxt;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign we_n = {wr_hi_n, wr_lo_n};

  dsb_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .we_n(we_n),
    .start_p(start_p), .start_c(start_c), .desel(desel), .cont(cont),
    .active_q(active_q), .sel_q(sel_q), .wl_q(wl_q)
  );

  dsb_burst_cnt #(.LINEAR(BURST_LINEAR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_p || start_c),
    .load_low(addr[1:0]), .step(cont && !adv_n),
    .low_q(low_q), .low_nxt(low_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 base_hi_q <= '0;
    else if (start_p || start_c) base_hi_q <= addr[ADDR_W-1:2];
  end

  assign wr_addr = start_c ? addr : {base_hi_q, low_nxt};
  assign rd_addr = {base_hi_q, low_q};

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign wr_lane[g]    = (start_c || cont) && !we_n[g];
    assign lane_drive[g] = !oe_n && sel_q && active_q && !wl_q[g];

    dsb_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk(clk), .we(wr_lane[g]), .waddr(wr_addr),
      .wd(wdata[g*LANE_W +: LANE_W]), .raddr(rd_addr),
      .rd(rdata[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dsb_burst_sram_chk.sv
module dsb_burst_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              wr_lo_n,
  input logic              wr_hi_n,
  input logic              adv_n,
  input logic              active_q,
  input logic [1:0]        wr_lane,
  input logic [1:0]        lane_drive,
  input logic [ADDR_W-1:0] rd_addr
);
  // R3: proc-strobe acceptance never stores, even with enables low
  a_r3_proc_edge_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !proc_strobe_n) |-> (wr_lane == 2'b00));

  // R4: ignored proc strobe leaves the burst address where it was
  a_r4_proc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && sel_n && ctrl_strobe_n && adv_n) |=> $stable(rd_addr));

  // R5: deselect silences both lanes in the next cycle
  a_r5_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !ctrl_strobe_n) |=> (lane_drive == 2'b00));

  // R7: controller-strobe write stores on the accepting edge
  a_r7_ctrl_write_now: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && proc_strobe_n && !ctrl_strobe_n && !wr_lo_n) |-> wr_lane[0]);

  // R12: a lane whose enable was sampled low is not driven
  a_r12_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo_n |=> !lane_drive[0]);
  a_r12_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi_n |=> !lane_drive[1]);
endmodule

bind dsb_burst_sram dsb_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .proc_strobe_n(proc_strobe_n),
  .ctrl_strobe_n(ctrl_strobe_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
  .adv_n(adv_n), .active_q(active_q), .wr_lane(wr_lane),
  .lane_drive(lane_drive), .rd_addr(rd_addr)
);

// File: tb/dsb_burst_sram_test.sv
module dsb_burst_sram_test;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int DW = 2 * LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_n, ctrl_n, sel_n, wlo_n, whi_n, adv_n, oe_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd_i, rd_l;
  logic [1:0]    dr_i, dr_l;

  dsb_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .BURST_LINEAR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_n),
    .ctrl_strobe_n(ctrl_n), .sel_n(sel_n), .wr_lo_n(wlo_n), .wr_hi_n(whi_n),
    .adv_n(adv_n), .oe_n(oe_n), .wdata(wdata), .rdata(rd_i), .lane_drive(dr_i));

  dsb_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .BURST_LINEAR(1'b1)) uut_lin (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_n),
    .ctrl_strobe_n(ctrl_n), .sel_n(sel_n), .wr_lo_n(wlo_n), .wr_hi_n(whi_n),
    .adv_n(adv_n), .oe_n(oe_n), .wdata(wdata), .rdata(rd_l), .lane_drive(dr_l));

  int checks = 0;
  int fails  = 0;

  // reference model, index 0 = interleaved instance, 1 = linear instance
  logic [LW-1:0] mm    [2][2][64];
  bit            known [2][2][64];
  bit            act   [2];
  int            base  [2];
  int            beat  [2];
  bit            selq;
  bit            wlq   [2];

  function automatic int burst_pos(int m, int s, int k);
    if (m == 0) return s ^ k;
    return (s + k) % 4;
  endfunction

  function automatic int cur_addr(int m);
    return (base[m] & ~3) | burst_pos(m, base[m] & 3, beat[m]);
  endfunction

  task automatic chk(string tag, string what, int a, int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, a, e);
    end
  endtask

  task automatic compare(string tag);
    for (int m = 0; m < 2; m++) begin
      logic [1:0]    drv;
      logic [DW-1:0] rdv;
      drv = (m == 0) ? dr_i : dr_l;
      rdv = (m == 0) ? rd_i : rd_l;
      for (int l = 0; l < 2; l++) begin
        bit exp_d;
        int ca;
        ca    = cur_addr(m);
        exp_d = !oe_n && selq && act[m] && !wlq[l];
        chk(tag, (m == 0) ? "drive(ilv)" : "drive(lin)", int'(drv[l]), int'(exp_d));
        if (exp_d && known[m][l][ca])
          chk(tag, (m == 0) ? "data(ilv)" : "data(lin)",
              int'(rdv[l*LW +: LW]), int'(mm[m][l][ca]));
      end
    end
  endtask

  task automatic model_edge();
    bit sp, sc, ds;
    bit [1:0] wen;
    sp  = !sel_n && !proc_n;
    sc  = !sel_n && proc_n && !ctrl_n;
    ds  = sel_n && !ctrl_n;
    wen = {!whi_n, !wlo_n};
    for (int m = 0; m < 2; m++) begin
      if (sp || sc) begin
        if (sc)
          for (int l = 0; l < 2; l++)
            if (wen[l]) begin
              mm[m][l][int'(addr)]    = wdata[l*LW +: LW];
              known[m][l][int'(addr)] = 1'b1;
            end
        act[m]  = 1'b1;
        base[m] = int'(addr);
        beat[m] = 0;
      end else if (ds) begin
        act[m] = 1'b0;
      end else if (act[m]) begin
        if (!adv_n) beat[m] = (beat[m] + 1) % 4;
        for (int l = 0; l < 2; l++)
          if (wen[l]) begin
            mm[m][l][cur_addr(m)]    = wdata[l*LW +: LW];
            known[m][l][cur_addr(m)] = 1'b1;
          end
      end
    end
    selq   = !sel_n;
    wlq[0] = !wlo_n;
    wlq[1] = !whi_n;
  endtask

  task automatic step(string tag, bit s_n, bit p_n, bit c_n, bit lo_n, bit hi_n,
                      bit a_n, int ad, logic [DW-1:0] wd);
    sel_n = s_n; proc_n = p_n; ctrl_n = c_n; wlo_n = lo_n; whi_n = hi_n;
    adv_n = a_n; addr = AW'(ad); wdata = wd;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic cwrite(string tag, int ad, logic [DW-1:0] wd, bit lo, bit hi);
    step(tag, 1'b0, 1'b1, 1'b0, !lo, !hi, 1'b1, ad, wd);
  endtask
  task automatic pread(string tag, int ad);
    step(tag, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, ad, '0);
  endtask
  task automatic hold(string tag, bit a_n);
    step(tag, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, a_n, 0, '0);
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin act[m] = 0; base[m] = 0; beat[m] = 0; end
    selq = 0; wlq[0] = 0; wlq[1] = 0;
    rst_n = 1'b0; sel_n = 1'b1; proc_n = 1'b1; ctrl_n = 1'b1;
    wlo_n = 1'b1; whi_n = 1'b1; adv_n = 1'b1; oe_n = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;
    step("R1", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, '0); // sel low, nothing open

    // R7 single-edge controller write, R2 read back
    cwrite("R7", 6'h10, 18'h2A5C3, 1, 1);
    pread("R2", 6'h10);
    hold("R2", 1'b1);

    // R8 per-lane writes
    cwrite("R8", 6'h11, 18'h3FFFF, 1, 1);
    cwrite("R8", 6'h11, 18'h00012, 1, 0);
    cwrite("R8", 6'h12, 18'h00000, 1, 1);
    cwrite("R8", 6'h12, 18'h3FE00, 0, 1);
    pread("R8", 6'h11);
    pread("R8", 6'h12);

    // R6 deferred processor write
    step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h20, 18'h11111);
    step("R6", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 18'h1BEEF);
    pread("R6", 6'h20);
    cwrite("R6", 6'h21, 18'h0ABCD, 1, 1);
    step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h21, 18'h3F00F);
    hold("R6", 1'b1);
    pread("R6", 6'h21);

    // R3 both strobes: processor wins, enables ignored
    cwrite("R3", 6'h22, 18'h05555, 1, 1);
    step("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h22, 18'h2AAAA);
    hold("R3", 1'b1);
    pread("R3", 6'h22);

    // R9/R10 bursts: fill 0x30..0x33, read from 0x31 with wrap
    for (int i = 0; i < 4; i++) cwrite("R9", 6'h30 + i, 18'(32'h101 * (i + 1)), 1, 1);
    pread("R10", 6'h31);
    for (int i = 0; i < 5; i++) hold("R9", 1'b0);
    pread("R10", 6'h32);
    for (int i = 0; i < 4; i++) hold("R10", 1'b0);

    // burst write continuing past the controller-strobe edge
    cwrite("R10", 6'h39, 18'h00777, 1, 1);
    for (int i = 0; i < 3; i++)
      step("R9", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 18'(32'h01010 + i));
    for (int i = 0; i < 4; i++) pread("R10", 6'h38 + i);

    // R11 advance ignored on the accepting edge
    step("R11", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h33, '0);
    hold("R11", 1'b1);

    // R4 / R13: processor strobe with sel high is ignored
    pread("R4", 6'h31);
    step("R13", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'h00, '0);
    hold("R4", 1'b1);

    // R5 deselect, stays quiet with sel low and no strobe
    step("R5", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0, '0);
    hold("R5", 1'b1);
    hold("R5", 1'b0);
    pread("R5", 6'h10);

    // R12 asynchronous output enable and write-lane turn-off
    oe_n = 1'b1; #1 compare("R12");
    oe_n = 1'b0; #1 compare("R12");
    step("R12", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 18'h00099);
    step("R12", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 0, 18'h16600);
    oe_n = 1'b1;
    step("R12", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 18'h00000);
    oe_n = 1'b0;
    hold("R12", 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule